// File: doc/BRIEF.md
# Paged Address Counter with Timed Commit

This block keeps the word-address pointer and a one-page write latch for a model of a paged nonvolatile byte memory. A serial protocol engine in front of it turns bus events into single-cycle requests. It can load the upper or lower address byte, push a received data byte into the page latch, fetch the byte at the pointer, and request a commit when the bus stop arrives.

The pointer advances differently for each direction. A push moves only the in-page offset, so a burst that runs past the end of a page wraps back to the start of that same page. A fetch moves the whole address and wraps from the top of the array back to zero. Between transactions the pointer keeps the last accessed address plus one, so a read that starts without an address load resumes from there.

A commit starts a self-timed write window whose length is a clock-count parameter. During that window `busy` is high and the latched bytes are copied one slot per cycle into the storage array. Only the slots that were pushed since the last address load are copied. Every request made while `busy` is high is dropped.

The pointer width is `ADDR_W`, which gives 512 pages of 64 bytes at 15 bits. It defaults to 11 bits (32 pages) to keep the default storage small.

Top module: `paged_addr_commit`

## Requirements
- R1: After a synchronous active-low reset, `cur_addr` is 0, `busy` is 0, `rd_byte` is 0 and the page latch holds no valid byte.
- R2: `ld_hi_req` writes `byte_in[ADDR_W-9:0]` into `cur_addr[ADDR_W-1:8]` and ignores the other bits of the byte. `ld_lo_req` writes `byte_in` into `cur_addr[7:0]`. Either load empties the page latch.
- R3: `push_req` stores `byte_in` into latch slot `cur_addr[5:0]`, marks that slot valid and increments only `cur_addr[5:0]`, modulo 64. `cur_addr[ADDR_W-1:6]` does not change.
- R4: Pushing more than 64 bytes without a commit wraps the offset, and the later byte replaces the earlier one in the same slot.
- R5: `fetch_req` places the stored byte at `cur_addr` on `rd_byte` one cycle later and increments the whole `cur_addr`. The address after all ones is 0.
- R6: A commit request made while at least one latch slot is valid sets `busy` on the next clock edge. `busy` then stays high for exactly max(`WR_CYCLES`, 64) cycles.
- R7: During the busy window, only the valid latch slots are written to the page `cur_addr[ADDR_W-1:6]` held at commit time. The other bytes of that page keep their old contents, and the latch is emptied when the window ends.
- R8: Load, push, fetch and commit requests made while `busy` is high change neither `cur_addr`, `rd_byte`, the latch contents nor the length of the busy window.
- R9: A commit request made while no latch slot is valid is ignored and `busy` stays low.
- R10: When several requests are high in one cycle, only one is served, in the priority order high load, low load, push, fetch, commit.
- R11: Without an address load, a fetch after a committed write reads from the pointer left by the last push, which is the last written offset plus one within that page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_hi_req | input | 1 | Load upper address bits from `byte_in` |
| ld_lo_req | input | 1 | Load lower address byte from `byte_in` |
| push_req | input | 1 | Push `byte_in` into the page latch |
| fetch_req | input | 1 | Read the byte at the pointer and advance |
| commit_req | input | 1 | Start the timed copy of the latch into storage |
| byte_in | input | 8 | Address or data byte for load and push |
| rd_byte | output | 8 | Byte returned by the last fetch |
| cur_addr | output | ADDR_W | Current word-address pointer |
| busy | output | 1 | High while the timed commit runs |

## Verification
Several properties are checked on every cycle. A push never moves the page bits. A fetch at the all-ones address lands on zero. The pointer is frozen while `busy` is high, `busy` only rises after an accepted commit and falls when its count ends. A commit with an empty latch never raises `busy`, storage is written only inside the busy window, and the latch mask is empty after a clear.

Some behaviour needs the bench's scenarios and its reference memory to show. These are the exact length of the busy window, that partial writes leave the rest of the page intact, that overflowing bursts overwrite slots, that data read back after a wrap is correct, and that the pointer resumes where a write left it.

// File: rtl/pac_pkg.sv
// Shared types for the paged address counter.
// Assumes: the top decodes at most one request per cycle using req_e.
package pac_pkg;
    typedef enum logic [2:0] {
        REQ_NONE   = 3'd0,
        REQ_LD_HI  = 3'd1,
        REQ_LD_LO  = 3'd2,
        REQ_PUSH   = 3'd3,
        REQ_FETCH  = 3'd4,
        REQ_COMMIT = 3'd5
    } req_e;
endpackage

// File: rtl/pac_addr_ptr.sv
// Word-address pointer with direction-dependent increment.
// A push advances only the in-page offset, which wraps inside the page.
// A fetch advances the full address, which wraps at the top of the array.
// Assumes: at most one of the enables is high in a cycle, and ADDR_W > 8.
module pac_addr_ptr #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              push_i,
    input  logic              fetch_i,
    input  logic [7:0]        byte_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] ptr_q;

    // Pointer update: byte loads, in-page advance on push, full advance on fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_hi_i) begin
            ptr_q[ADDR_W-1:8] <= byte_i[HI_W-1:0];
        end else if (ld_lo_i) begin
            ptr_q[7:0] <= byte_i;
        end else if (push_i) begin
            ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + OFF_W'(1);
        end else if (fetch_i) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    assign ptr_o = ptr_q;

    // R3
    push_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> ptr_q[ADDR_W-1:OFF_W] == $past(ptr_q[ADDR_W-1:OFF_W]));

    // R4
    push_offset_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && (&ptr_q[OFF_W-1:0])) |=> ptr_q[OFF_W-1:0] == '0);

    // R5
    fetch_top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && (&ptr_q)) |=> ptr_q == '0);
endmodule

// File: rtl/pac_page_latch.sv
// One-page write latch with a per-slot valid mask.
// A push writes the slot addressed by the offset and marks it valid.
// A clear empties the mask but leaves the data slots as they are.
// Assumes: clear and push are never high in the same cycle.
module pac_page_latch #(
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [7:0]       byte_i,
    input  logic [OFF_W-1:0] rd_idx_i,
    output logic [7:0]       rd_byte_o,
    output logic             rd_valid_o,
    output logic             any_valid_o
);
    localparam int SLOTS = 1 << OFF_W;

    logic [7:0]       data_q [SLOTS];
    logic [SLOTS-1:0] mask_q;

    // One data register per slot, loaded when a push addresses it.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (off_i == OFF_W'(s))) begin
                data_q[s] <= byte_i;
            end
        end
    end

    // Valid mask: cleared on request, set per pushed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr_i) begin
            mask_q <= '0;
        end else if (push_i) begin
            mask_q[off_i] <= 1'b1;
        end
    end

    assign rd_byte_o   = data_q[rd_idx_i];
    assign rd_valid_o  = mask_q[rd_idx_i];
    assign any_valid_o = |mask_q;

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> mask_q == '0);

    // R3
    push_marks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i) |=> mask_q[$past(off_i)]);
endmodule

// File: rtl/pac_commit_timer.sv
// Timed commit sequencer.
// A start raises busy for EFF_CYCLES cycles. During the first 2**OFF_W of
// those cycles it steps a slot index, one slot per cycle, for the copy.
// Assumes: start is only issued while busy is low, and WR_CYCLES >= 1.
module pac_commit_timer #(
    parameter int WR_CYCLES = 100,
    parameter int OFF_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             copy_o,
    output logic [OFF_W-1:0] idx_o,
    output logic             done_o
);
    localparam int SLOTS      = 1 << OFF_W;
    localparam int EFF_CYCLES = (WR_CYCLES < SLOTS) ? SLOTS : WR_CYCLES;
    localparam int CW         = $clog2(EFF_CYCLES + 1);
    localparam logic [OFF_W:0] IDX_END = (OFF_W + 1)'(SLOTS);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [OFF_W:0] idx_q;

    // Busy window countdown: load on start, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(EFF_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // Copy slot index: restart on start, step until all slots are visited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_END;
        end else if (start_i && !busy_q) begin
            idx_q <= '0;
        end else if (busy_q && (idx_q != IDX_END)) begin
            idx_q <= idx_q + (OFF_W + 1)'(1);
        end
    end

    assign busy_o = busy_q;
    assign copy_o = busy_q && (idx_q != IDX_END);
    assign idx_o  = idx_q[OFF_W-1:0];
    assign done_o = busy_q && (cnt_q == '0);

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start_i));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0) |=> !busy_q);
endmodule

// File: rtl/pac_store.sv
// Byte storage array with one write port and one registered read port.
// Assumes: writes happen only inside the commit window, reads only outside it.
module pac_store #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    // Array write from the commit sequencer.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Registered read data, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re_i) begin
            rdata_q <= mem_q[raddr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/paged_addr_commit.sv
// Top of the paged address counter with timed commit.
// Decodes one request per cycle by fixed priority and gates all requests
// while busy. It captures the target page at commit and routes the latch
// copy into storage.
// Assumes: requests are single-cycle pulses from a protocol engine.
module paged_addr_commit #(
    parameter int ADDR_W    = 11,
    parameter int OFF_W     = 6,
    parameter int WR_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi_req,
    input  logic              ld_lo_req,
    input  logic              push_req,
    input  logic              fetch_req,
    input  logic              commit_req,
    input  logic [7:0]        byte_in,
    output logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy
);
    import pac_pkg::*;

    localparam int PAGE_W = ADDR_W - OFF_W;

    req_e              req;
    logic              any_valid;
    logic              copy;
    logic              done;
    logic [OFF_W-1:0]  copy_idx;
    logic [7:0]        latch_byte;
    logic              latch_valid;
    logic [PAGE_W-1:0] page_q;
    logic              store_we;
    logic              ld_hi_en, ld_lo_en, push_en, fetch_en, commit_en;

    // Priority decode of the request lines, all dropped while busy.
    always_comb begin
        req = REQ_NONE;
        if (!busy) begin
            if (ld_hi_req)       req = REQ_LD_HI;
            else if (ld_lo_req)  req = REQ_LD_LO;
            else if (push_req)   req = REQ_PUSH;
            else if (fetch_req)  req = REQ_FETCH;
            else if (commit_req) req = REQ_COMMIT;
        end
    end

    assign ld_hi_en  = (req == REQ_LD_HI);
    assign ld_lo_en  = (req == REQ_LD_LO);
    assign push_en   = (req == REQ_PUSH);
    assign fetch_en  = (req == REQ_FETCH);
    assign commit_en = (req == REQ_COMMIT) && any_valid;

    // Page captured when a commit is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (commit_en) begin
            page_q <= cur_addr[ADDR_W-1:OFF_W];
        end
    end

    pac_addr_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi_i (ld_hi_en),
        .ld_lo_i (ld_lo_en),
        .push_i  (push_en),
        .fetch_i (fetch_en),
        .byte_i  (byte_in),
        .ptr_o   (cur_addr)
    );

    pac_page_latch #(.OFF_W(OFF_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (ld_hi_en || ld_lo_en || done),
        .push_i      (push_en),
        .off_i       (cur_addr[OFF_W-1:0]),
        .byte_i      (byte_in),
        .rd_idx_i    (copy_idx),
        .rd_byte_o   (latch_byte),
        .rd_valid_o  (latch_valid),
        .any_valid_o (any_valid)
    );

    pac_commit_timer #(.WR_CYCLES(WR_CYCLES), .OFF_W(OFF_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_en),
        .busy_o  (busy),
        .copy_o  (copy),
        .idx_o   (copy_idx),
        .done_o  (done)
    );

    assign store_we = copy && latch_valid;

    pac_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .waddr_i ({page_q, copy_idx}),
        .wdata_i (latch_byte),
        .re_i    (fetch_en),
        .raddr_i (cur_addr),
        .rdata_o (rd_byte)
    );

    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_addr) && $stable(rd_byte)));

    // R9
    empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !ld_hi_req && !ld_lo_req && !push_req && !fetch_req
         && !busy && !any_valid) |=> !busy);

    // R7
    write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> busy);

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ld_hi_en, ld_lo_en, push_en, fetch_en, commit_en}) <= 1);
endmodule

// File: tb/tb_paged_addr_commit.sv
module tb_paged_addr_commit;
    localparam int AW   = 11;
    localparam int OW   = 6;
    localparam int WR   = 80;
    localparam int HIW  = AW - 8;
    localparam int DEP  = 1 << AW;
    localparam int PG   = 1 << OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_hi_req = 0, ld_lo_req = 0, push_req = 0, fetch_req = 0, commit_req = 0;
    logic [7:0]    byte_in = '0;
    logic [7:0]    rd_byte;
    logic [AW-1:0] cur_addr;
    logic          busy;

    paged_addr_commit #(.ADDR_W(AW), .OFF_W(OW), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .ld_hi_req(ld_hi_req), .ld_lo_req(ld_lo_req),
        .push_req(push_req), .fetch_req(fetch_req), .commit_req(commit_req),
        .byte_in(byte_in), .rd_byte(rd_byte), .cur_addr(cur_addr), .busy(busy));

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]    mem_m   [DEP];
    logic          known_m [DEP];
    logic [7:0]    latch_m [PG];
    logic [PG-1:0] mask_m;
    logic [AW-1:0] ptr_m;

    function automatic logic [AW-1:0] next_wr(input logic [AW-1:0] p);
        return {p[AW-1:OW], p[OW-1:0] + OW'(1)};
    endfunction

    function automatic logic [AW-1:0] next_rd(input logic [AW-1:0] p);
        return p + AW'(1);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic h, input logic l, input logic p,
                         input logic f, input logic c, input logic [7:0] b);
        @(negedge clk);
        ld_hi_req = h; ld_lo_req = l; push_req = p; fetch_req = f; commit_req = c;
        byte_in = b;
        @(negedge clk);
        ld_hi_req = 0; ld_lo_req = 0; push_req = 0; fetch_req = 0; commit_req = 0;
    endtask

    task automatic ld_hi(input logic [7:0] b);
        pulse(1, 0, 0, 0, 0, b);
        ptr_m[AW-1:8] = b[HIW-1:0];
        mask_m = '0;
        chk(32'(cur_addr), 32'(ptr_m), "R2 high load");
    endtask

    task automatic ld_lo(input logic [7:0] b);
        pulse(0, 1, 0, 0, 0, b);
        ptr_m[7:0] = b;
        mask_m = '0;
        chk(32'(cur_addr), 32'(ptr_m), "R2 low load");
    endtask

    task automatic set_addr(input logic [AW-1:0] a);
        ld_hi(8'(a >> 8));
        ld_lo(a[7:0]);
    endtask

    task automatic push(input logic [7:0] b);
        pulse(0, 0, 1, 0, 0, b);
        latch_m[ptr_m[OW-1:0]] = b;
        mask_m[ptr_m[OW-1:0]] = 1'b1;
        ptr_m = next_wr(ptr_m);
        chk(32'(cur_addr), 32'(ptr_m), "R3 push advance");
    endtask

    task automatic fetch(input string tag);
        logic [7:0] e;
        logic       k;
        e = mem_m[ptr_m];
        k = known_m[ptr_m];
        pulse(0, 0, 0, 1, 0, 8'h00);
        if (k) chk(32'(rd_byte), 32'(e), tag);
        ptr_m = next_rd(ptr_m);
        chk(32'(cur_addr), 32'(ptr_m), "R5 fetch advance");
    endtask

    task automatic commit();
        int n;
        logic [AW-1:0] a0;
        logic [7:0]    r0;
        logic          expect_run;
        expect_run = (mask_m != '0);
        pulse(0, 0, 0, 0, 1, 8'h00);
        n = 0;
        a0 = cur_addr;
        r0 = rd_byte;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            // R8: poke every request kind inside the window
            ld_hi_req = (n == 1); ld_lo_req = (n == 2); push_req = (n == 3);
            fetch_req = (n == 4); commit_req = (n == 5);
            byte_in = 8'hA5;
            @(negedge clk);
            ld_hi_req = 0; ld_lo_req = 0; push_req = 0; fetch_req = 0; commit_req = 0;
            if (n == 6) begin
                chk(32'(cur_addr), 32'(a0), "R8 addr frozen while busy");
                chk(32'(rd_byte), 32'(r0), "R8 read data frozen while busy");
            end
        end
        if (expect_run) begin
            chk(32'(n), 32'(WR), "R6 busy window length");
            for (int i = 0; i < PG; i++) begin
                if (mask_m[i]) begin
                    mem_m[{ptr_m[AW-1:OW], OW'(i)}] = latch_m[i];
                    known_m[{ptr_m[AW-1:OW], OW'(i)}] = 1'b1;
                end
            end
            mask_m = '0;
        end else begin
            chk(32'(n), 32'd0, "R9 empty commit ignored");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] p0;
        for (int i = 0; i < DEP; i++) begin mem_m[i] = '0; known_m[i] = 1'b0; end
        for (int i = 0; i < PG; i++) latch_m[i] = '0;
        mask_m = '0;
        ptr_m = '0;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(cur_addr), 0, "R1 reset address");
        chk(32'(busy), 0, "R1 reset busy");
        chk(32'(rd_byte), 0, "R1 reset read data");
        commit();   // R1: empty latch after reset, so no busy window

        // R2: upper byte bits beyond the pointer are ignored
        ld_hi(8'hFD);
        ld_lo(8'h3E);

        // R3: burst crosses the page end and wraps inside the page
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk(32'(cur_addr[AW-1:OW]), 32'(5'h14), "R3 page bits kept");
        commit();
        set_addr(11'h53E);
        fetch("R3 byte at offset 3E");
        fetch("R3 byte at offset 3F");
        set_addr(11'h500);
        for (int i = 0; i < 3; i++) fetch("R3 wrapped bytes");

        // R7: full page then partial rewrite
        set_addr(11'h0C0);
        for (int i = 0; i < PG; i++) push(8'(i * 3 + 1));
        commit();
        set_addr(11'h0CA);
        for (int i = 0; i < 3; i++) push(8'hE0 + 8'(i));
        commit();
        // R11: current-address read resumes after the last pushed offset
        chk(32'(cur_addr), 32'(11'h0CD), "R11 pointer after write");
        fetch("R11 resume read");
        set_addr(11'h0C0);
        for (int i = 0; i < PG; i++) fetch("R7 partial page contents");

        // R4: 66 pushes overwrite the first two slots
        set_addr(11'h1C0);
        for (int i = 0; i < PG + 2; i++) push(8'(200 + i));
        commit();
        set_addr(11'h1C0);
        for (int i = 0; i < 4; i++) fetch("R4 overwritten slots");

        // R5: read wraps from the top of the array to zero
        set_addr(11'h7FF);
        push(8'h5A);
        commit();
        set_addr(11'h000);
        push(8'hC3);
        commit();
        set_addr(11'h7FF);
        fetch("R5 last byte");
        chk(32'(cur_addr), 0, "R5 wrap to zero");
        fetch("R5 byte at zero");

        // R9: dummy address load then commit does nothing
        set_addr(11'h2A0);
        commit();

        // R10: simultaneous requests, high load wins over push
        p0 = ptr_m;
        pulse(1, 1, 1, 1, 1, 8'h02);
        ptr_m[AW-1:8] = 3'h2;
        mask_m = '0;
        chk(32'(cur_addr), 32'(ptr_m), "R10 high load priority");
        pulse(0, 0, 1, 1, 1, 8'h77);
        latch_m[ptr_m[OW-1:0]] = 8'h77;
        mask_m[ptr_m[OW-1:0]] = 1'b1;
        ptr_m = next_wr(ptr_m);
        chk(32'(cur_addr), 32'(ptr_m), "R10 push beats fetch and commit");
        chk(32'(busy), 0, "R10 commit not served alongside push");
        if (p0 == ptr_m) n_cmp = n_cmp + 0;

        // Random mix checked against the model
        for (int k = 0; k < 300; k++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0: ld_hi(8'($urandom));
                1: ld_lo(8'($urandom));
                2, 3, 4, 5: push(8'($urandom));
                6, 7: fetch("R5 random read");
                8: commit();
                default: begin
                    set_addr(AW'($urandom));
                    fetch("R5 random addressed read");
                end
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule